// File: doc/BRIEF.md
# Ready/Busy Status Pin Configurator

This block drives the open-drain style status pin of a memory controller. In its default level mode the pin is pulled low while the controller's internal state machine is busy and is released (output enable off) when the machine is ready. Three pulse modes turn the pin into an interrupt source. In these modes the pin gives a short low pulse when an operation of a selected class completes: erase-type, write-type, or either.

The state machine reports each completion with a one-cycle strobe and an operation tag. A configuration write stores a 2-bit mode code. That code stays in force until another write, a power-down (`pwrdn_n` low) or an exit from deep power-down (`dpd_exit`). Both of those events return the block to level mode. The pin drive value is always low whenever the output enable is on. A board pull-up supplies the high level otherwise.

Top module: `sts_pin_cfg`

## Requirements
- R1: After `rst_n` is released the mode is level (code 00) and no pulse is pending, so `sts_oe` equals `busy`.
- R2: In level mode `sts_oe` is 1 in the same cycle that `busy` is 1 and 0 when `busy` is 0. `sts_o` is 0 whenever `sts_oe` is 1 and 1 otherwise.
- R3: Code 01 makes a pulse only for completions tagged 0 (block erase), 1 (full erase) or 2 (lock-bit clear).
- R4: Code 10 makes a pulse only for completions tagged 3 (single write), 4 (multi write) or 5 (lock-bit set).
- R5: Code 11 makes a pulse for tags 0 to 5. Tags 6 and 7 never make a pulse in any mode.
- R6: A pulse holds `sts_oe` at 1 for exactly PULSE_LEN cycles (default 4), starting in the cycle after the strobe. In pulse modes `busy` has no effect on the pin.
- R7: A qualifying completion during a pulse restarts the count at PULSE_LEN. Completions are not queued.
- R8: A configuration write (`cfg_we`) changes the mode at the next clock edge. A strobe in the same cycle is judged by the old mode. The mode is otherwise kept across any number of operations.
- R9: `pwrdn_n` low or `dpd_exit` high returns the mode to 00 at the next edge and cancels any pulse in progress.
- R10: A configuration write while `pwrdn_n` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_code | input | 2 | Mode code written with `cfg_we` |
| busy | input | 1 | State machine busy |
| done_vld | input | 1 | One-cycle completion strobe |
| done_op | input | 3 | Tag of the completed operation |
| pwrdn_n | input | 1 | Reset/power-down, active low |
| dpd_exit | input | 1 | Deep power-down exit event |
| sts_o | output | 1 | Pin drive value (0 when enabled) |
| sts_oe | output | 1 | Pin output enable (0 = high impedance) |

## Verification
Every tag from 0 to 7 is sent to the block under each of the four codes. This separates the erase class, the write class, the union of both, and the reserved tags that are always dropped. `busy` is toggled in level mode and again in pulse modes, which shows that the pin follows `busy` only when the code is 00. A second completion is sent in the middle of a pulse to show that the count restarts rather than queues. Configuration writes are given alongside strobes, during power-down and next to a deep power-down exit, which fixes the priority and timing of mode changes.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_ALL   = 2'b11
  } sts_mode_e;

  typedef enum logic [2:0] {
    OP_BLK_ERASE  = 3'd0,
    OP_CHIP_ERASE = 3'd1,
    OP_LOCK_CLR   = 3'd2,
    OP_BYTE_WR    = 3'd3,
    OP_MULTI_WR   = 3'd4,
    OP_LOCK_SET   = 3'd5,
    OP_RSVD6      = 3'd6,
    OP_RSVD7      = 3'd7
  } op_kind_e;
endpackage

// File: rtl/sts_mode_reg.sv
module sts_mode_reg
  import sts_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  logic [1:0] cfg_code,
  input  logic      pwrdn_n,
  input  logic      dpd_exit,
  output sts_mode_e mode_q
);
  sts_mode_e mode_d;
  logic      mode_en;

  always_comb begin
    mode_en = 1'b0;
    mode_d  = mode_q;
    if (!pwrdn_n || dpd_exit) begin
      mode_en = 1'b1;
      mode_d  = MODE_LEVEL;
    end else if (cfg_we) begin
      mode_en = 1'b1;
      mode_d  = sts_mode_e'(cfg_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_LEVEL;
    else if (mode_en) mode_q <= mode_d;
  end

  // R9
  pwr_event_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrdn_n || dpd_exit) |=> (mode_q == MODE_LEVEL));
  // R10
  cfg_in_pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !pwrdn_n) |=> (mode_q == MODE_LEVEL));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !dpd_exit && !cfg_we) |=> $stable(mode_q));
endmodule

// File: rtl/sts_class_filter.sv
module sts_class_filter
  import sts_pkg::*;
(
  input  sts_mode_e  mode,
  input  logic [2:0] op,
  output logic       match
);
  logic is_erase, is_write;

  always_comb begin
    is_erase = 1'b0;
    is_write = 1'b0;
    case (op_kind_e'(op))
      OP_BLK_ERASE, OP_CHIP_ERASE, OP_LOCK_CLR: is_erase = 1'b1;
      OP_BYTE_WR, OP_MULTI_WR, OP_LOCK_SET:     is_write = 1'b1;
      default: ;
    endcase
    case (mode)
      MODE_ERASE: match = is_erase;
      MODE_WRITE: match = is_write;
      MODE_ALL:   match = is_erase | is_write;
      default:    match = 1'b0;
    endcase
  end

  // R2
  always_comb begin
    level_nomatch_chk: assert (!(match && (mode == MODE_LEVEL)));
  end
endmodule

// File: rtl/sts_pulse_gen.sv
module sts_pulse_gen #(
  parameter int PULSE_LEN = 4,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic level,
  output logic active
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (clr || (level && !hit)) cnt_d = '0;
    else if (hit)               cnt_d = LOAD;
    else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
    else                        cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R7
  retrigger_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (cnt_q == LOAD));
  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr && !level && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !active);
endmodule

// File: rtl/sts_pin_cfg.sv
module sts_pin_cfg
  import sts_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_code,
  input  logic       busy,
  input  logic       done_vld,
  input  logic [2:0] done_op,
  input  logic       pwrdn_n,
  input  logic       dpd_exit,
  output logic       sts_o,
  output logic       sts_oe
);
  sts_mode_e mode_q;
  logic      match, hit, clr, level, pulse_active;

  assign clr   = !pwrdn_n || dpd_exit;
  assign level = (mode_q == MODE_LEVEL);
  assign hit   = done_vld && match && !clr;

  sts_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .pwrdn_n(pwrdn_n), .dpd_exit(dpd_exit), .mode_q(mode_q)
  );

  sts_class_filter u_filt (.mode(mode_q), .op(done_op), .match(match));

  sts_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .level(level),
    .active(pulse_active)
  );

  assign sts_oe = level ? busy : pulse_active;
  assign sts_o  = !sts_oe;

  // R6
  busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && !pulse_active) |-> !sts_oe);
  // R5
  rsvd_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_op[2:1] == 2'b11 && !pulse_active) |=> !pulse_active);
endmodule

// File: tb/sts_pin_cfg_bench.sv
module sts_pin_cfg_bench;
  localparam int PL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_code = 2'b00;
  logic busy = 1'b0;
  logic done_vld = 1'b0;
  logic [2:0] done_op = 3'd0;
  logic pwrdn_n = 1'b1;
  logic dpd_exit = 1'b0;
  logic sts_o, sts_oe;

  int n_run = 0;
  int n_fail = 0;
  int m_mode = 0;
  int m_cnt = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  sts_pin_cfg #(.PULSE_LEN(PL)) u_sts_pin_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .busy(busy), .done_vld(done_vld), .done_op(done_op),
    .pwrdn_n(pwrdn_n), .dpd_exit(dpd_exit), .sts_o(sts_o), .sts_oe(sts_oe)
  );

  function automatic bit in_class(int mode, int op);
    bit er = (op == 0) || (op == 1) || (op == 2);
    bit wr = (op == 3) || (op == 4) || (op == 5);
    if (mode == 1) return er;
    if (mode == 2) return wr;
    if (mode == 3) return er || wr;
    return 1'b0;
  endfunction

  // reference model, advanced on each edge from the inputs held since the last negedge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_cnt  = 0;
    end else begin
      bit c, h;
      c = !pwrdn_n || dpd_exit;
      h = done_vld && in_class(m_mode, int'(done_op)) && !c;
      if (c) m_cnt = 0;
      else if (h) m_cnt = PL;
      else if (m_mode == 0) m_cnt = 0;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (c) m_mode = 0;
      else if (cfg_we) m_mode = int'(cfg_code);
    end
  end

  task automatic compare();
    logic exp_oe;
    exp_oe = (m_mode == 0) ? busy : (m_cnt != 0);
    n_run++;
    if (sts_oe !== exp_oe || sts_o !== !exp_oe) begin
      n_fail++;
      $display("FAIL %s: sts_oe=%b sts_o=%b expected oe=%b o=%b (mode %0d)",
               tag, sts_oe, sts_o, exp_oe, !exp_oe, m_mode);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 compare();
      cfg_we = 1'b0; done_vld = 1'b0; dpd_exit = 1'b0;
    end
  endtask

  task automatic cfg(int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_code = 2'(code);
    step(1);
  endtask

  task automatic done(int op);
    @(negedge clk);
    done_vld = 1'b1; done_op = 3'(op);
    step(1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    tag = "R1";
    repeat (2) @(negedge clk);
    n_run++;
    if (sts_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: sts_oe=%b expected 0 in reset", sts_oe);
    end
    rst_n = 1'b1;
    step(2);
    // R2 level mode follows busy
    tag = "R2";
    busy = 1'b1; step(3);
    busy = 1'b0; step(2);
    done(0); step(2);
    busy = 1'b1; step(1); busy = 1'b0; step(1);
    // R3 erase class
    tag = "R3";
    cfg(1);
    for (int op = 0; op < 8; op++) begin done(op); step(PL + 1); end
    // R4 write class
    tag = "R4";
    cfg(2);
    for (int op = 0; op < 8; op++) begin done(op); step(PL + 1); end
    // R5 both classes, reserved tags
    tag = "R5";
    cfg(3);
    for (int op = 0; op < 8; op++) begin done(op); step(PL + 1); end
    // R6 busy ignored in pulse modes, exact width
    tag = "R6";
    busy = 1'b1; step(3);
    done(4); step(PL + 2);
    busy = 1'b0;
    // R7 retrigger restarts
    tag = "R7";
    done(1); step(2); done(5); step(1); done(2); step(PL + 2);
    // R8 strobe with a cfg write uses old mode; mode persists
    tag = "R8";
    @(negedge clk); cfg_we = 1'b1; cfg_code = 2'd2; done_vld = 1'b1; done_op = 3'd0;
    step(PL + 2);
    done(0); step(2);
    for (int k = 0; k < 6; k++) begin done(3); step(PL + 3); end
    // R9 power-down and deep power-down exit
    tag = "R9";
    done(3); step(1);
    pwrdn_n = 1'b0; step(3);
    busy = 1'b1; step(2); busy = 1'b0;
    pwrdn_n = 1'b1; step(2);
    // R10 cfg ignored during power-down
    tag = "R10";
    pwrdn_n = 1'b0; cfg(3); step(1);
    pwrdn_n = 1'b1; step(1);
    done(0); step(PL + 1);
    busy = 1'b1; step(1); busy = 1'b0;
    tag = "R9";
    cfg(3); done(2); step(1);
    @(negedge clk); dpd_exit = 1'b1; step(2);
    done(2); step(2);
    busy = 1'b1; step(2); busy = 1'b0; step(1);
    // dpd exit outranks a simultaneous cfg write
    @(negedge clk); dpd_exit = 1'b1; cfg_we = 1'b1; cfg_code = 2'd3;
    step(1);
    done(1); step(PL + 1);
    tag = "R1";
    cfg(2); done(3); step(1);
    rst_n = 1'b0; #1;
    n_run++;
    if (sts_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: sts_oe=%b expected 0 after async reset", sts_oe);
    end
    step(1); rst_n = 1'b1; step(1);
    done(3); step(3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule